// File: doc/BRIEF.md
# Superscalar Instruction Grouping Unit

This decode-stage unit holds a window of up to three decoded instructions. Each cycle it decides how many of the oldest ones can issue together as one group. Every instruction arrives with:

- a branch flag;
- a two-bit class;
- an optional destination register;
- up to two optional source registers.

The unit reports the group size and a valid mask, and presents the window contents to the next stage. When that stage takes the group, the issued entries leave the window. The rest shift down, and one new instruction per cycle is accepted from a valid/ready input port.

A group may hold three members only when its first member is a branch; otherwise it holds at most two. A branch later in the window always starts a new group. A member that reads a register written by an older member of the group stops the group before it. The one exception is a register-copy producer feeding a simple arithmetic consumer, which the forwarding path covers. Two members that write the same register are never grouped.

Top module: `instr_grouper`

## Requirements
- R1: During and right after reset the window is empty: grp_valid=0, grp_size=0, grp_mask=0, in_ready=1.
- R2: When the oldest window entry is not a branch, the group has at most 2 members; when it is a branch, up to 3.
- R3: An entry whose branch flag is set never joins a group in slot 1 or 2; the group ends before it.
- R4: An entry whose enabled source A or source B equals the enabled destination of an older group member ends the group before it. A source with its enable low never causes this, whatever its register number.
- R5: The rule of R4 is waived when the producer has class 1 (register copy) and the consumer has class 2 (simple arithmetic). Classes 0 (other) and 3 (load) have no waiver.
- R6: An entry whose enabled destination equals the enabled destination of an older group member ends the group before it, even when R5 applies.
- R7: The group size equals the number of window entries when fewer are present than the rules allow. grp_valid is high exactly when the window holds at least one entry, and then grp_size is at least 1.
- R8: grp_mask has bit k set exactly when k < grp_size.
- R9: in_ready is high exactly when the window would still have a free entry after the current group leaves; a group leaves only when out_ready is high. With out_ready low, the oldest entry stays unchanged.
- R10: Instructions leave in arrival order with all fields intact. grp_slots holds slot k at bits [k*18 +: 18], and each instruction is laid out as follows: bit 0 is the branch flag, bits 2:1 the class, bit 3 the destination enable, bits 7:4 the destination, bit 8 the source A enable, bits 12:9 source A, bit 13 the source B enable, and bits 17:14 source B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction valid |
| in_ready | output | 1 | Window can accept the incoming instruction this cycle |
| in_br | input | 1 | Incoming branch flag |
| in_cls | input | 2 | Incoming class (0 other, 1 copy, 2 arithmetic, 3 load) |
| in_dst_en | input | 1 | Incoming destination enable |
| in_dst | input | REG_W | Incoming destination register |
| in_sa_en | input | 1 | Incoming source A enable |
| in_sa | input | REG_W | Incoming source A register |
| in_sb_en | input | 1 | Incoming source B enable |
| in_sb | input | REG_W | Incoming source B register |
| out_ready | input | 1 | Next stage takes the current group |
| grp_valid | output | 1 | Window holds at least one instruction |
| grp_size | output | 2 | Number of instructions in the current group |
| grp_mask | output | 3 | Per-slot membership of the current group |
| grp_slots | output | 3*(6+3*REG_W) | Window contents, oldest in slot 0 |

## Verification
The group outputs (grp_size, grp_mask, grp_slots, grp_valid) come from combinational logic on the window registers. An instruction accepted at one clock edge therefore affects them in the cycle after that edge. in_ready reacts within the same cycle to out_ready and the current group size. The bench drives inputs just after the falling edge and compares all outputs one time step later against a queue model of the window. The model is updated at the rising edge, consuming the predicted group and appending the accepted instruction. Each directed grouping case fills the window with out_ready low and then reads the size in the following cycle.

// File: rtl/gi_pkg.sv
package gi_pkg;
    localparam int GI_SLOTS = 3;

    localparam logic [1:0] CLS_OTHER = 2'd0;
    localparam logic [1:0] CLS_COPY  = 2'd1;
    localparam logic [1:0] CLS_ARITH = 2'd2;
    localparam logic [1:0] CLS_LOAD  = 2'd3;

    function automatic int gi_word_w(input int reg_w);
        return 6 + 3 * reg_w;
    endfunction
endpackage

// File: rtl/gi_pair_hazard.sv
module gi_pair_hazard
    import gi_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic [1:0]       p_cls,
    input  logic             p_den,
    input  logic [REG_W-1:0] p_dst,
    input  logic [1:0]       c_cls,
    input  logic             c_den,
    input  logic [REG_W-1:0] c_dst,
    input  logic             c_aen,
    input  logic [REG_W-1:0] c_a,
    input  logic             c_ben,
    input  logic [REG_W-1:0] c_b,
    output logic             blocked
);
    logic raw_hit;
    logic fwd_ok;
    logic waw_hit;

    always_comb begin
        raw_hit = p_den && ((c_aen && (c_a == p_dst)) || (c_ben && (c_b == p_dst)));
        fwd_ok  = (p_cls == CLS_COPY) && (c_cls == CLS_ARITH);
        waw_hit = p_den && c_den && (c_dst == p_dst);
        blocked = (raw_hit && !fwd_ok) || waw_hit;
    end
endmodule

// File: rtl/gi_group_sel.sv
module gi_group_sel
    import gi_pkg::*;
#(
    parameter int REG_W = 4,
    localparam int CW = $clog2(GI_SLOTS + 1)
) (
    input  logic [CW-1:0]                   cnt,
    input  logic [GI_SLOTS-1:0]             br,
    input  logic [GI_SLOTS-1:0][1:0]        cls,
    input  logic [GI_SLOTS-1:0]             den,
    input  logic [GI_SLOTS-1:0][REG_W-1:0]  dst,
    input  logic [GI_SLOTS-1:1]             aen,
    input  logic [GI_SLOTS-1:1][REG_W-1:0]  sa,
    input  logic [GI_SLOTS-1:1]             ben,
    input  logic [GI_SLOTS-1:1][REG_W-1:0]  sb,
    output logic [CW-1:0]                   size
);
    // pair k: 0 -> (0,1), 1 -> (0,2), 2 -> (1,2)
    localparam int NPAIR = 3;
    logic [NPAIR-1:0] blk;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int P = (k == 2) ? 1 : 0;
        localparam int C = (k == 0) ? 1 : 2;
        gi_pair_hazard #(.REG_W(REG_W)) u_haz (
            .p_cls  (cls[P]),
            .p_den  (den[P]),
            .p_dst  (dst[P]),
            .c_cls  (cls[C]),
            .c_den  (den[C]),
            .c_dst  (dst[C]),
            .c_aen  (aen[C]),
            .c_a    (sa[C]),
            .c_ben  (ben[C]),
            .c_b    (sb[C]),
            .blocked(blk[k])
        );
    end

    logic join1;
    logic join2;

    always_comb begin
        join1 = (cnt >= CW'(2)) && !br[1] && !blk[0];
        join2 = join1 && br[0] && (cnt == CW'(3)) && !br[2] && !blk[1] && !blk[2];
        if (cnt == '0) begin
            size = '0;
        end else begin
            size = CW'(1) + CW'(join1) + CW'(join2);
        end
    end
endmodule

// File: rtl/gi_window.sv
module gi_window
    import gi_pkg::*;
#(
    parameter int IW = 18,
    localparam int CW = $clog2(GI_SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [IW-1:0]                 in_word,
    output logic                          in_ready,
    input  logic                          take,
    input  logic [CW-1:0]                 size,
    output logic [GI_SLOTS-1:0][IW-1:0]   slots,
    output logic [CW-1:0]                 cnt
);
    typedef struct packed {
        logic [GI_SLOTS-1:0][IW-1:0] slot;
        logic [CW-1:0]               cnt;
    } win_t;

    win_t st_d;
    win_t st_q;
    int   consume;
    int   rem;

    always_comb begin
        st_d     = st_q;
        consume  = (take && (st_q.cnt != '0)) ? int'(size) : 0;
        rem      = int'(st_q.cnt) - consume;
        for (int k = 0; k < GI_SLOTS; k++) begin
            if (k + consume < GI_SLOTS) begin
                st_d.slot[k] = st_q.slot[k + consume];
            end else begin
                st_d.slot[k] = '0;
            end
        end
        st_d.cnt = CW'(rem);
        in_ready = (rem < GI_SLOTS);
        if (in_valid && (rem < GI_SLOTS)) begin
            st_d.slot[rem] = in_word;
            st_d.cnt       = CW'(rem + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slots = st_q.slot;
    assign cnt   = st_q.cnt;
endmodule

// File: rtl/instr_grouper.sv
module instr_grouper
    import gi_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic                          in_br,
    input  logic [1:0]                    in_cls,
    input  logic                          in_dst_en,
    input  logic [REG_W-1:0]              in_dst,
    input  logic                          in_sa_en,
    input  logic [REG_W-1:0]              in_sa,
    input  logic                          in_sb_en,
    input  logic [REG_W-1:0]              in_sb,
    input  logic                          out_ready,
    output logic                          grp_valid,
    output logic [1:0]                    grp_size,
    output logic [2:0]                    grp_mask,
    output logic [3*(6+3*REG_W)-1:0]      grp_slots
);
    localparam int IW    = gi_word_w(REG_W);
    localparam int CW    = $clog2(GI_SLOTS + 1);
    localparam int O_BR  = 0;
    localparam int O_CLS = 1;
    localparam int O_DEN = 3;
    localparam int O_DST = 4;
    localparam int O_AEN = 4 + REG_W;
    localparam int O_SA  = 5 + REG_W;
    localparam int O_BEN = 5 + 2 * REG_W;
    localparam int O_SB  = 6 + 2 * REG_W;

    logic [IW-1:0]                   in_word;
    logic [GI_SLOTS-1:0][IW-1:0]     win_slots;
    logic [CW-1:0]                   win_cnt;
    logic [CW-1:0]                   sel_size;

    logic [GI_SLOTS-1:0]             f_br;
    logic [GI_SLOTS-1:0][1:0]        f_cls;
    logic [GI_SLOTS-1:0]             f_den;
    logic [GI_SLOTS-1:0][REG_W-1:0]  f_dst;
    logic [GI_SLOTS-1:1]             f_aen;
    logic [GI_SLOTS-1:1][REG_W-1:0]  f_sa;
    logic [GI_SLOTS-1:1]             f_ben;
    logic [GI_SLOTS-1:1][REG_W-1:0]  f_sb;

    assign in_word = {in_sb, in_sb_en, in_sa, in_sa_en, in_dst, in_dst_en, in_cls, in_br};

    gi_window #(.IW(IW)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_word (in_word),
        .in_ready(in_ready),
        .take    (out_ready),
        .size    (sel_size),
        .slots   (win_slots),
        .cnt     (win_cnt)
    );

    for (genvar s = 0; s < GI_SLOTS; s++) begin : g_fields
        assign f_br[s]  = win_slots[s][O_BR];
        assign f_cls[s] = win_slots[s][O_CLS +: 2];
        assign f_den[s] = win_slots[s][O_DEN];
        assign f_dst[s] = win_slots[s][O_DST +: REG_W];
        if (s > 0) begin : g_src
            assign f_aen[s] = win_slots[s][O_AEN];
            assign f_sa[s]  = win_slots[s][O_SA +: REG_W];
            assign f_ben[s] = win_slots[s][O_BEN];
            assign f_sb[s]  = win_slots[s][O_SB +: REG_W];
        end
    end

    gi_group_sel #(.REG_W(REG_W)) u_sel (
        .cnt (win_cnt),
        .br  (f_br),
        .cls (f_cls),
        .den (f_den),
        .dst (f_dst),
        .aen (f_aen),
        .sa  (f_sa),
        .ben (f_ben),
        .sb  (f_sb),
        .size(sel_size)
    );

    assign grp_valid = (win_cnt != '0);
    assign grp_size  = sel_size;
    assign grp_slots = win_slots;

    for (genvar s = 0; s < GI_SLOTS; s++) begin : g_mask
        assign grp_mask[s] = (sel_size > CW'(s));
    end
endmodule

// File: rtl/gi_checker.sv
module gi_checker #(
    parameter int REG_W = 4,
    localparam int IW = 6 + 3 * REG_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_ready,
    input logic             grp_valid,
    input logic [1:0]       grp_size,
    input logic [IW-1:0]    s0,
    input logic             s1_br,
    input logic             s1_den,
    input logic [REG_W-1:0] s1_dst,
    input logic             s2_br
);
    AST_PLAIN_HEAD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !s0[0]) |-> (grp_size <= 2'd2)); // R2

    AST_NO_LATE_BRANCH_1: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_size >= 2'd2) |-> !s1_br); // R3

    AST_NO_LATE_BRANCH_2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_size == 2'd3) |-> !s2_br); // R3

    AST_WAW_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_size >= 2'd2) && s0[3] && s1_den) |-> (s0[7:4] != s1_dst[3:0])); // R6

    AST_NONEMPTY_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (grp_size != 2'd0)); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && !out_ready) |=> (grp_valid && $stable(s0))); // R9

    AST_REFILL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (grp_valid && !out_ready)); // R9
endmodule

bind instr_grouper gi_checker #(.REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_ready(out_ready),
    .grp_valid(grp_valid),
    .grp_size (grp_size),
    .s0       (grp_slots[IW-1:0]),
    .s1_br    (grp_slots[IW]),
    .s1_den   (grp_slots[IW+3]),
    .s1_dst   (grp_slots[IW+4 +: REG_W]),
    .s2_br    (grp_slots[2*IW])
);

// File: tb/instr_grouper_test.sv
module instr_grouper_test;
    localparam int REG_W = 4;
    localparam int IW    = 18;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_br = 1'b0;
    logic [1:0]       in_cls = '0;
    logic             in_dst_en = 1'b0;
    logic [REG_W-1:0] in_dst = '0;
    logic             in_sa_en = 1'b0;
    logic [REG_W-1:0] in_sa = '0;
    logic             in_sb_en = 1'b0;
    logic [REG_W-1:0] in_sb = '0;
    logic             out_ready = 1'b0;
    logic             grp_valid;
    logic [1:0]       grp_size;
    logic [2:0]       grp_mask;
    logic [3*IW-1:0]  grp_slots;

    instr_grouper #(.REG_W(REG_W)) uut (.*);

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "R2";
    logic [IW-1:0] win_q[$];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    function automatic logic [IW-1:0] mk(input bit br, input int cls, input bit den, input int d,
                                         input bit aen, input int a, input bit ben, input int b);
        return {4'(b), ben, 4'(a), aen, 4'(d), den, 2'(cls), br};
    endfunction

    function automatic bit hazard(input logic [IW-1:0] p, input logic [IW-1:0] c);
        bit raw, fwd, waw;
        raw = p[3] && ((c[8] && c[12:9] == p[7:4]) || (c[13] && c[17:14] == p[7:4]));
        fwd = (p[2:1] == 2'd1) && (c[2:1] == 2'd2);
        waw = p[3] && c[3] && (c[7:4] == p[7:4]);
        return (raw && !fwd) || waw;
    endfunction

    function automatic int model_size();
        int lim, n;
        bit stop;
        if (win_q.size() == 0) return 0;
        lim = win_q[0][0] ? 3 : 2;
        n = 1;
        while (n < lim && n < win_q.size()) begin
            stop = win_q[n][0];
            for (int j = 0; j < n; j++) if (hazard(win_q[j], win_q[n])) stop = 1;
            if (stop) break;
            n++;
        end
        return n;
    endfunction

    task automatic cyc(input bit ordy, input bit ivld, input logic [IW-1:0] w);
        int es, consume;
        bit er;
        out_ready = ordy;
        in_valid  = ivld;
        {in_sb, in_sb_en, in_sa, in_sa_en, in_dst, in_dst_en, in_cls, in_br} = w;
        #1;
        es = model_size();
        consume = ordy ? es : 0;
        er = (win_q.size() - consume) < 3;
        chk(int'(grp_size) == es, cur_tag, grp_size, es);
        chk(grp_valid == (win_q.size() != 0), "R7", grp_valid, win_q.size() != 0);
        chk(grp_mask == 3'((1 << es) - 1), "R8", grp_mask, (1 << es) - 1);
        chk(in_ready == er, "R9", in_ready, er);
        for (int s = 0; s < es; s++)
            chk(grp_slots[s*IW +: IW] == win_q[s], "R10", grp_slots[s*IW +: IW], win_q[s]);
        @(posedge clk);
        repeat (consume) void'(win_q.pop_front());
        if (ivld && er) win_q.push_back(w);
        @(negedge clk);
    endtask

    task automatic drain();
        while (win_q.size() != 0) cyc(1'b1, 1'b0, '0);
    endtask

    task automatic load3(input string tag, input logic [IW-1:0] a, input logic [IW-1:0] b,
                         input logic [IW-1:0] c);
        drain();
        cur_tag = tag;
        cyc(1'b0, 1'b1, a);
        cyc(1'b0, 1'b1, b);
        cyc(1'b0, 1'b1, c);
        cyc(1'b0, 1'b0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(grp_valid == 1'b0, "R1", grp_valid, 0);
        chk(grp_size == 2'd0, "R1", grp_size, 0);
        chk(grp_mask == 3'd0, "R1", grp_mask, 0);
        chk(in_ready == 1'b1, "R1", in_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";
        cyc(1'b1, 1'b0, '0);

        // R2: branch head allows three; plain head caps at two
        load3("R2", mk(1,0,1,1,0,0,0,0), mk(0,2,1,2,1,5,0,0), mk(0,3,1,3,1,6,0,0));
        load3("R2", mk(0,0,1,1,0,0,0,0), mk(0,2,1,2,1,5,0,0), mk(0,3,1,3,1,6,0,0));
        // R3: later branch closes the group
        load3("R3", mk(1,0,0,0,0,0,0,0), mk(0,0,1,2,0,0,0,0), mk(1,0,0,0,0,0,0,0));
        load3("R3", mk(0,0,1,2,0,0,0,0), mk(1,0,0,0,0,0,0,0), mk(0,0,1,3,0,0,0,0));
        // R4: read-after-write split, disabled source ignored
        load3("R4", mk(0,0,1,4,0,0,0,0), mk(0,0,1,5,0,0,1,4), mk(0,0,0,0,0,0,0,0));
        load3("R4", mk(0,0,1,4,0,0,0,0), mk(0,0,1,5,0,4,0,4), mk(0,0,0,0,0,0,0,0));
        load3("R4", mk(1,0,1,4,0,0,0,0), mk(0,0,1,5,0,0,0,0), mk(0,0,1,6,1,5,0,0));
        // R5: copy -> arithmetic forwarding waiver
        load3("R5", mk(0,1,1,5,0,0,0,0), mk(0,2,1,6,1,5,0,0), mk(0,0,0,0,0,0,0,0));
        load3("R5", mk(0,2,1,5,0,0,0,0), mk(0,2,1,6,1,5,0,0), mk(0,0,0,0,0,0,0,0));
        load3("R5", mk(0,1,1,5,0,0,0,0), mk(0,3,1,6,1,5,0,0), mk(0,0,0,0,0,0,0,0));
        load3("R5", mk(1,0,0,0,0,0,0,0), mk(0,1,1,6,0,0,0,0), mk(0,2,1,7,0,0,1,6));
        // R6: same destination never grouped, even with the waiver
        load3("R6", mk(0,0,1,7,0,0,0,0), mk(0,0,1,7,0,0,0,0), mk(0,0,0,0,0,0,0,0));
        load3("R6", mk(0,1,1,7,0,0,0,0), mk(0,2,1,7,1,7,0,0), mk(0,0,0,0,0,0,0,0));
        // R7: lone entry forms a group of one
        drain();
        cur_tag = "R7";
        cyc(1'b0, 1'b1, mk(1,0,0,0,0,0,0,0));
        cyc(1'b0, 1'b0, '0);
        // R9: full window with stalled output refuses input, then accepts
        load3("R9", mk(0,0,1,1,0,0,0,0), mk(0,0,1,1,0,0,0,0), mk(0,0,1,2,0,0,0,0));
        cyc(1'b0, 1'b1, mk(0,0,1,9,0,0,0,0));
        cyc(1'b1, 1'b1, mk(0,0,1,9,0,0,0,0));
        drain();

        // R10 and all grouping rules under random traffic
        cur_tag = "R2";
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 4) != 0,
                mk(($urandom % 4) == 0, $urandom % 4, $urandom % 2, $urandom % 4,
                   $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 4));
        end
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule